// File: doc/BRIEF.md
# Dual-Port RAM with Per-Port Collision Flags

This block is a synchronous RAM with two independent read/write ports, A and B, both clocked by one clock. Each port has its own enable, write enable, output-clear input, address, write data and read data. A port that is enabled and not writing reads the addressed word. A port that writes stores its data and shows that data on its own output in the same access. A port that is not enabled keeps its output unchanged.

Both ports can target the same word in the same cycle. The block treats this as a conflict when both ports are enabled, their addresses are equal, and at least one of them writes. Each port has a collision flag, raised in the cycle after the access, that tells the user not to trust that port's output. When both ports write the same word, the word is also marked as corrupt. A later read of a marked word raises that port's bad-data flag. The mark is removed when the word is written again without a conflict. A synchronous block reset clears the outputs, the flags and all marks. It does not touch the stored data.

Top module: `dpr_collide_ram`

## Requirements
- R1: With enable high and write enable low, the port's output shows the contents of the addressed word on the cycle after the clock edge.
- R2: With enable high and write enable high, the data is stored at the address, and the same port's output shows that data on the cycle after the edge.
- R3: With enable low, the port's output keeps its previous value, and its collision and bad-data flags read 0. This holds even when the output-clear input is high.
- R4: With enable high and output-clear high, the port's output becomes 0 on the next cycle. A write in the same access is still stored, and the memory contents are otherwise unchanged.
- R5: A write on one port is seen by a later read of the same word on the other port. A port's output does not change when the other port writes the word it last read; the new value appears only after that port reads again.
- R6: When both ports write the same address in one cycle, both collision flags are 1 for one cycle and each output shows its own port's write data. A later read of that word raises that port's bad-data flag.
- R7: When one port writes and the other reads the same address in one cycle, the writer's collision flag is 0 and its output shows its write data. The reader's collision flag is 1 for that cycle. A later read of the word returns the new data with the bad-data flag 0.
- R8: Two reads of the same address, and accesses to different addresses, raise no collision flag.
- R9: A conflict-free write to a word marked corrupt removes the mark, so the next read of that word has its bad-data flag at 0.
- R10: While the block reset is high, both outputs and all four flags are 0 on the next cycle and every corrupt mark is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high block reset |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write enable |
| a_oclr | input | 1 | Port A output clear (synchronous, needs enable) |
| a_addr | input | AW | Port A address |
| a_wdata | input | DW | Port A write data |
| a_rdata | output | DW | Port A output data |
| a_coll | output | 1 | Port A collision flag, one cycle |
| a_bad | output | 1 | Port A read of a corrupt-marked word |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write enable |
| b_oclr | input | 1 | Port B output clear (synchronous, needs enable) |
| b_addr | input | AW | Port B address |
| b_wdata | input | DW | Port B write data |
| b_rdata | output | DW | Port B output data |
| b_coll | output | 1 | Port B collision flag, one cycle |
| b_bad | output | 1 | Port B read of a corrupt-marked word |

## Verification
The vector table runs the ports through several patterns. One port writes while the other idles, which separates write-through from hold. Writes on one port are followed by reads on the other, which shows cross-port visibility and that a reader's output stays put. Both ports access different addresses at once to rule out false collisions. Same-address read/read, write/read and write/write cycles separate the three conflict outcomes by which flags rise and whether a later read is marked bad. Directed steps cover output clear with and without a write, clear held low by a disabled port, clearing of a corrupt mark by a clean write, and removal of marks by the block reset.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } port_op_e;

    typedef struct packed {
        logic coll;
        logic bad;
    } port_flag_t;

    typedef struct packed {
        logic both_wr;
        logic inv_a;
        logic inv_b;
    } clash_t;

    function automatic port_op_e op_of(input logic en, input logic we);
        if (!en)
            return OP_IDLE;
        return we ? OP_WRITE : OP_READ;
    endfunction

endpackage

// File: rtl/dpr_clash.sv
module dpr_clash
    import dpr_pkg::*;
#(
    parameter int AW = 8
) (
    input  port_op_e        op_a,
    input  port_op_e        op_b,
    input  logic [AW-1:0]   addr_a,
    input  logic [AW-1:0]   addr_b,
    output clash_t          cl
);

    logic same, a_act, b_act, a_wr, b_wr, hit;

    always_comb begin
        same  = (addr_a == addr_b);
        a_act = (op_a != OP_IDLE);
        b_act = (op_b != OP_IDLE);
        a_wr  = (op_a == OP_WRITE);
        b_wr  = (op_b == OP_WRITE);
        hit   = same && a_act && b_act && (a_wr || b_wr);
        cl.both_wr = hit && a_wr && b_wr;
        cl.inv_a   = hit && b_wr;
        cl.inv_b   = hit && a_wr;
    end

endmodule

// File: rtl/dpr_store.sv
module dpr_store #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_a,
    input  logic [AW-1:0]   addr_a,
    input  logic [DW-1:0]   din_a,
    input  logic            wr_b,
    input  logic [AW-1:0]   addr_b,
    input  logic [DW-1:0]   din_b,
    input  logic            poison,
    output logic [DW-1:0]   rdat_a,
    output logic [DW-1:0]   rdat_b,
    output logic            mark_a,
    output logic            mark_b
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0]    mem [DEPTH];
    logic [DEPTH-1:0] marks;

    // Port A is applied last, so it owns the word on a double write.
    always_ff @(posedge clk) begin
        if (wr_b)
            mem[addr_b] <= din_b;
        if (wr_a)
            mem[addr_a] <= din_a;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            marks <= '0;
        end else begin
            if (wr_b)
                marks[addr_b] <= 1'b0;
            if (wr_a)
                marks[addr_a] <= poison;
        end
    end

    assign rdat_a = mem[addr_a];
    assign rdat_b = mem[addr_b];
    assign mark_a = marks[addr_a];
    assign mark_b = marks[addr_b];

endmodule

// File: rtl/dpr_port.sv
module dpr_port
    import dpr_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  port_op_e        op,
    input  logic            oclr,
    input  logic [DW-1:0]   wdata,
    input  logic [DW-1:0]   rdata,
    input  logic            mark,
    input  logic            coll_in,
    output logic [DW-1:0]   dout,
    output port_flag_t      flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
            flag <= '0;
        end else begin
            flag <= '0;
            unique case (op)
                OP_WRITE: begin
                    dout      <= oclr ? '0 : wdata;
                    flag.coll <= coll_in;
                end
                OP_READ: begin
                    dout      <= oclr ? '0 : rdata;
                    flag.coll <= coll_in;
                    flag.bad  <= mark && !oclr;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dpr_collide_ram.sv
module dpr_collide_ram
    import dpr_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            a_en,
    input  logic            a_we,
    input  logic            a_oclr,
    input  logic [AW-1:0]   a_addr,
    input  logic [DW-1:0]   a_wdata,
    output logic [DW-1:0]   a_rdata,
    output logic            a_coll,
    output logic            a_bad,
    input  logic            b_en,
    input  logic            b_we,
    input  logic            b_oclr,
    input  logic [AW-1:0]   b_addr,
    input  logic [DW-1:0]   b_wdata,
    output logic [DW-1:0]   b_rdata,
    output logic            b_coll,
    output logic            b_bad
);

    localparam int NPORT = 2;

    port_op_e        op    [NPORT];
    logic            oclr  [NPORT];
    logic [DW-1:0]   wdat  [NPORT];
    logic [DW-1:0]   rdat  [NPORT];
    logic            mark  [NPORT];
    logic            inv   [NPORT];
    logic [DW-1:0]   dout  [NPORT];
    port_flag_t      flg   [NPORT];
    clash_t          cl;

    assign op[0]   = op_of(a_en, a_we);
    assign op[1]   = op_of(b_en, b_we);
    assign oclr[0] = a_oclr;
    assign oclr[1] = b_oclr;
    assign wdat[0] = a_wdata;
    assign wdat[1] = b_wdata;
    assign inv[0]  = cl.inv_a;
    assign inv[1]  = cl.inv_b;

    dpr_clash #(.AW(AW)) u_clash (
        .op_a   (op[0]),
        .op_b   (op[1]),
        .addr_a (a_addr),
        .addr_b (b_addr),
        .cl     (cl)
    );

    dpr_store #(.AW(AW), .DW(DW)) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_a   (op[0] == OP_WRITE),
        .addr_a (a_addr),
        .din_a  (a_wdata),
        .wr_b   (op[1] == OP_WRITE),
        .addr_b (b_addr),
        .din_b  (b_wdata),
        .poison (cl.both_wr),
        .rdat_a (rdat[0]),
        .rdat_b (rdat[1]),
        .mark_a (mark[0]),
        .mark_b (mark[1])
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        dpr_port #(.DW(DW)) u_port (
            .clk     (clk),
            .rst     (rst),
            .op      (op[p]),
            .oclr    (oclr[p]),
            .wdata   (wdat[p]),
            .rdata   (rdat[p]),
            .mark    (mark[p]),
            .coll_in (inv[p]),
            .dout    (dout[p]),
            .flag    (flg[p])
        );
    end

    assign a_rdata = dout[0];
    assign b_rdata = dout[1];
    assign a_coll  = flg[0].coll;
    assign b_coll  = flg[1].coll;
    assign a_bad   = flg[0].bad;
    assign b_bad   = flg[1].bad;

endmodule

// File: rtl/dpr_collide_chk.sv
module dpr_collide_chk #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            a_en,
    input logic            a_we,
    input logic            a_oclr,
    input logic [AW-1:0]   a_addr,
    input logic [DW-1:0]   a_wdata,
    input logic [DW-1:0]   a_rdata,
    input logic            a_coll,
    input logic            a_bad,
    input logic            b_en,
    input logic            b_we,
    input logic            b_oclr,
    input logic [AW-1:0]   b_addr,
    input logic [DW-1:0]   b_wdata,
    input logic [DW-1:0]   b_rdata,
    input logic            b_coll,
    input logic            b_bad
);

    p_write_through_r2: assert property (@(posedge clk) disable iff (rst)
        (a_en && a_we && !a_oclr) |=> (a_rdata == $past(a_wdata)));

    p_hold_off_r3: assert property (@(posedge clk) disable iff (rst)
        !b_en |=> ($stable(b_rdata) && !b_coll && !b_bad));

    p_out_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (a_en && a_oclr) |=> (a_rdata == '0));

    p_double_write_r6: assert property (@(posedge clk) disable iff (rst)
        (a_en && b_en && a_we && b_we && a_addr == b_addr) |=> (a_coll && b_coll));

    p_write_read_r7: assert property (@(posedge clk) disable iff (rst)
        (a_en && a_we && b_en && !b_we && a_addr == b_addr) |=> (b_coll && !a_coll));

    p_no_false_r8: assert property (@(posedge clk) disable iff (rst)
        (a_en && b_en && !a_we && !b_we) |=> (!a_coll && !b_coll));

    p_reset_r10: assert property (@(posedge clk)
        rst |=> (a_rdata == '0 && b_rdata == '0 && !a_coll && !b_coll && !a_bad && !b_bad));

endmodule

bind dpr_collide_ram dpr_collide_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst(rst),
    .a_en(a_en), .a_we(a_we), .a_oclr(a_oclr), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_coll(a_coll), .a_bad(a_bad),
    .b_en(b_en), .b_we(b_we), .b_oclr(b_oclr), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_coll(b_coll), .b_bad(b_bad)
);

// File: tb/dpr_collide_ram_test.sv
module dpr_collide_ram_test;

    localparam int AW = 8;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst;
    logic a_en, a_we, a_oclr, b_en, b_we, b_oclr;
    logic [AW-1:0] a_addr, b_addr;
    logic [DW-1:0] a_wdata, b_wdata;
    logic [DW-1:0] a_rdata, b_rdata;
    logic a_coll, a_bad, b_coll, b_bad;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dpr_collide_ram #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .rst(rst),
        .a_en(a_en), .a_we(a_we), .a_oclr(a_oclr), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_coll(a_coll), .a_bad(a_bad),
        .b_en(b_en), .b_we(b_we), .b_oclr(b_oclr), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_coll(b_coll), .b_bad(b_bad)
    );

    typedef struct packed {
        logic          ae;
        logic          awe;
        logic [7:0]    aad;
        logic [15:0]   adi;
        logic          be;
        logic          bwe;
        logic [7:0]    bad;
        logic [15:0]   bdi;
        logic          ca;
        logic [15:0]   ea;
        logic          cb;
        logic [15:0]   eb;
        logic [3:0]    ef;   // {a_coll, b_coll, a_bad, b_bad}
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{1,1,8'h10,16'h1111, 0,0,8'h00,16'h0000, 1,16'h1111, 1,16'h0000, 4'b0000}, // R2
        '{0,0,8'h00,16'h0000, 1,0,8'h10,16'h0000, 1,16'h1111, 1,16'h1111, 4'b0000}, // R5 R3
        '{1,1,8'h10,16'h2222, 0,0,8'h00,16'h0000, 1,16'h2222, 1,16'h1111, 4'b0000}, // R5 hold
        '{0,0,8'h00,16'h0000, 1,0,8'h10,16'h0000, 1,16'h2222, 1,16'h2222, 4'b0000}, // R1 R5
        '{1,1,8'h7E,16'h9999, 1,1,8'h30,16'h3333, 1,16'h9999, 1,16'h3333, 4'b0000}, // R8 distinct
        '{1,0,8'h30,16'h0000, 1,0,8'h7E,16'h0000, 1,16'h3333, 1,16'h9999, 4'b0000}, // R1 R5
        '{1,1,8'h30,16'h4444, 1,0,8'h30,16'h0000, 1,16'h4444, 0,16'h0000, 4'b0100}, // R7
        '{1,0,8'h30,16'h0000, 1,0,8'h30,16'h0000, 1,16'h4444, 1,16'h4444, 4'b0000}, // R7 R8
        '{1,1,8'h40,16'h5555, 1,1,8'h40,16'h6666, 1,16'h5555, 1,16'h6666, 4'b1100}, // R6
        '{1,0,8'h40,16'h0000, 1,0,8'h7E,16'h0000, 0,16'h0000, 1,16'h9999, 4'b0010}, // R6 marked
        '{0,0,8'h00,16'h0000, 1,1,8'h40,16'h7777, 0,16'h0000, 1,16'h7777, 4'b0000}, // R9
        '{1,0,8'h40,16'h0000, 0,0,8'h00,16'h0000, 1,16'h7777, 1,16'h7777, 4'b0000}  // R9
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic ae, input logic awe, input logic aclr,
                         input logic [7:0] aad, input logic [15:0] adi,
                         input logic be, input logic bwe, input logic bclr,
                         input logic [7:0] bad, input logic [15:0] bdi);
        a_en = ae; a_we = awe; a_oclr = aclr; a_addr = aad; a_wdata = adi;
        b_en = be; b_we = bwe; b_oclr = bclr; b_addr = bad; b_wdata = bdi;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1;
        drive(0,0,0,8'h00,16'h0, 0,0,0,8'h00,16'h0);
        drive(0,0,0,8'h00,16'h0, 0,0,0,8'h00,16'h0);
        chk("R10 reset a_rdata", 32'(a_rdata), 32'h0);
        chk("R10 reset b_rdata", 32'(b_rdata), 32'h0);
        chk("R10 reset flags", {28'h0, a_coll, b_coll, a_bad, b_bad}, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].ae, TBL[i].awe, 1'b0, TBL[i].aad, TBL[i].adi,
                  TBL[i].be, TBL[i].bwe, 1'b0, TBL[i].bad, TBL[i].bdi);
            if (TBL[i].ca)
                chk($sformatf("vec %0d R1 R2 R5 a_rdata", i), 32'(a_rdata), 32'(TBL[i].ea));
            if (TBL[i].cb)
                chk($sformatf("vec %0d R1 R2 R5 b_rdata", i), 32'(b_rdata), 32'(TBL[i].eb));
            chk($sformatf("vec %0d R6 R7 R8 R9 flags", i),
                {28'h0, a_coll, b_coll, a_bad, b_bad}, 32'(TBL[i].ef));
        end

        // R4: clear on a read, memory unchanged
        drive(1,0,1,8'h7E,16'h0, 0,0,0,8'h00,16'h0);
        chk("R4 clear on read", 32'(a_rdata), 32'h0);
        drive(1,0,0,8'h7E,16'h0, 0,0,0,8'h00,16'h0);
        chk("R4 memory kept", 32'(a_rdata), 32'h9999);
        // R4: clear with a write still stores
        drive(1,1,1,8'h50,16'hABCD, 0,0,0,8'h00,16'h0);
        chk("R4 clear on write", 32'(a_rdata), 32'h0);
        drive(0,0,0,8'h00,16'h0, 1,0,0,8'h50,16'h0);
        chk("R4 write stored", 32'(b_rdata), 32'hABCD);
        // R3: clear ignored while disabled
        drive(0,0,0,8'h00,16'h0, 0,0,1,8'h50,16'h0);
        chk("R3 disabled clear held", 32'(b_rdata), 32'hABCD);
        chk("R3 disabled flags", {30'h0, b_coll, b_bad}, 32'h0);

        // R7: B writes, A reads same word
        drive(1,0,0,8'h70,16'h0, 1,1,0,8'h70,16'h1234);
        chk("R7 writer output", 32'(b_rdata), 32'h1234);
        chk("R7 flags", {28'h0, a_coll, b_coll, a_bad, b_bad}, 32'b1000);
        drive(1,0,0,8'h70,16'h0, 0,0,0,8'h00,16'h0);
        chk("R7 new data", 32'(a_rdata), 32'h1234);
        chk("R7 no mark", {31'h0, a_bad}, 32'h0);

        // R10: reset clears corrupt marks
        drive(1,1,0,8'h60,16'h0001, 1,1,0,8'h60,16'h0002);
        chk("R6 second double write", {30'h0, a_coll, b_coll}, 32'b11);
        rst = 1'b1;
        drive(0,0,0,8'h00,16'h0, 0,0,0,8'h00,16'h0);
        rst = 1'b0;
        chk("R10 mid reset outputs", {a_rdata, b_rdata}, 32'h0);
        drive(1,0,0,8'h60,16'h0, 1,0,0,8'h60,16'h0);
        chk("R10 mark cleared", {28'h0, a_coll, b_coll, a_bad, b_bad}, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule